// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Latch Controller

This block holds the digital state of a two-channel converter and updates it from complete 16-bit command words. Each word arrives with a one-cycle valid strobe, already assembled by an upstream receiver. The block keeps three data registers: an output latch for channel A, an output latch for channel B, and a staging register that feeds channel B. It also keeps a reference-select code, a speed flag and a power-down flag.

Two non-adjacent address bits in the word choose one of four write actions. One of those actions loads channel A and, in the same cycle, moves the staged value into channel B. Software can therefore stage a value for B and then change both outputs together with a single write to A.

The latch, staging and mode values are all visible as outputs. Two gated code outputs feed the converters downstream. They read zero while the block is powered down and return to the held latch values when it wakes.

Top module: `dual_latch_ctrl`

## Requirements
- R1: After reset, every data register is zero, the reference select is 00 (external), the speed flag is 0 (slow) and the power-down flag is 0 (active).
- R2: A word with address bits {bit15,bit12} = 00 writes data field bits 11:2 to both the channel B latch and the staging register, and leaves the channel A latch unchanged.
- R3: A word with address 01 writes the data field to the staging register only; both output latches keep their values.
- R4: A word with address 10 writes the data field to the channel A latch and, in the same cycle, loads the channel B latch with the staging value held before that word; the staging register is unchanged.
- R5: A word with address 11 loads the reference select from bits 1:0 (00 external, 01 low internal, 10 high internal, 11 external); the latches and the staging register are unchanged, and no other address changes the reference select.
- R6: Bit 14 of every accepted word, whatever its address, sets the speed flag (1 fast, 0 slow).
- R7: Bit 13 of every accepted word sets the power-down flag (1 powered down). While the flag is set, both gated code outputs are zero. When it clears, they show the latch values again.
- R8: Data writes accepted while powered down still update the latches and the staging register, and those values appear on the gated outputs after wake-up.
- R9: Without a valid strobe, no register changes, whatever the value on the word input.
- R10: For data writes, bits 1:0 of the word take no part in the data value and do not alter the reference select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a committed word |
| cmd_word | input | 16 | Command word |
| lat_a | output | 10 | Channel A latch |
| lat_b | output | 10 | Channel B latch |
| stage_b | output | 10 | Channel B staging register |
| ref_sel | output | 2 | Reference-select code |
| fast_mode | output | 1 | Speed flag, 1 is fast |
| pwr_down | output | 1 | Power-down flag |
| out_code_a | output | 10 | Channel A code after power gating |
| out_code_b | output | 10 | Channel B code after power gating |

## Verification
The hardest state to reach from the ports is a staging register that differs from the channel B latch at the moment of a channel A write. That state exists only after a staging-only write. The bench makes it with a staging-only write followed by an A write, and checks that B takes the staged value while the staging register stays the same. It then issues a second A write, which must leave B alone. The wake-up path is covered by writing new codes while powered down and checking that they appear only after the flag clears.

// File: rtl/dual_latch_ctrl.sv
module dual_latch_ctrl #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [DW+5:0] cmd_word,
  output logic [DW-1:0] lat_a,
  output logic [DW-1:0] lat_b,
  output logic [DW-1:0] stage_b,
  output logic [1:0]    ref_sel,
  output logic          fast_mode,
  output logic          pwr_down,
  output logic [DW-1:0] out_code_a,
  output logic [DW-1:0] out_code_b
);
  localparam int WW   = DW + 6;
  localparam int P_HI = WW - 1;
  localparam int P_SP = WW - 2;
  localparam int P_PD = WW - 3;
  localparam int P_LO = WW - 4;

  logic [1:0]    sel;
  logic [DW-1:0] data;

  assign sel  = {cmd_word[P_HI], cmd_word[P_LO]};
  assign data = cmd_word[DW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a     <= '0;
      lat_b     <= '0;
      stage_b   <= '0;
      ref_sel   <= 2'b00;
      fast_mode <= 1'b0;
      pwr_down  <= 1'b0;
    end else if (cmd_valid) begin
      fast_mode <= cmd_word[P_SP];
      pwr_down  <= cmd_word[P_PD];
      case (sel)
        2'b00: begin
          lat_b   <= data;
          stage_b <= data;
        end
        2'b01: stage_b <= data;
        2'b10: begin
          lat_a <= data;
          lat_b <= stage_b;
        end
        default: ref_sel <= cmd_word[1:0];
      endcase
    end
  end

  assign out_code_a = pwr_down ? '0 : lat_a;
  assign out_code_b = pwr_down ? '0 : lat_b;

  p_a_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel != 2'b10) |=> $stable(lat_a));

  p_latches_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel == 2'b01) |=> ($stable(lat_a) && $stable(lat_b)));

  p_b_from_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel == 2'b10) |=> (lat_b == $past(stage_b) && $stable(stage_b)));

  p_ref_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel != 2'b11) |=> $stable(ref_sel));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(lat_a) && $stable(lat_b) && $stable(stage_b)
                    && $stable(ref_sel) && $stable(fast_mode) && $stable(pwr_down)));
endmodule

// File: tb/sim_dual_latch_ctrl.sv
module sim_dual_latch_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [15:0] cmd_word = '0;
  logic [9:0]  lat_a, lat_b, stage_b, out_code_a, out_code_b;
  logic [1:0]  ref_sel;
  logic        fast_mode, pwr_down;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [9:0] ea = 0, eb = 0, es = 0;
  logic [1:0] eref = 0;
  logic       efast = 0, epd = 0;

  dual_latch_ctrl u0 (.clk, .rst_n, .cmd_valid, .cmd_word, .lat_a, .lat_b, .stage_b,
    .ref_sel, .fast_mode, .pwr_down, .out_code_a, .out_code_b);

  always #4 clk = ~clk;

  function automatic logic [15:0] mk(bit r1, bit fs, bit pd, bit r0, logic [9:0] d, logic [1:0] lo);
    return {r1, fs, pd, r0, d, lo};
  endfunction

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "lat_a", 16'(lat_a), 16'(ea));
    chk(req, "lat_b", 16'(lat_b), 16'(eb));
    chk(req, "stage_b", 16'(stage_b), 16'(es));
    chk(req, "ref_sel", 16'(ref_sel), 16'(eref));
    chk(req, "fast", 16'(fast_mode), 16'(efast));
    chk(req, "pd", 16'(pwr_down), 16'(epd));
    chk(req, "out_a", 16'(out_code_a), epd ? 16'h0 : 16'(ea));
    chk(req, "out_b", 16'(out_code_b), epd ? 16'h0 : 16'(eb));
  endtask

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_word = 16'hFFFF;
    efast = w[14]; epd = w[13];
    case ({w[15], w[12]})
      2'b00: begin eb = w[11:2]; es = w[11:2]; end
      2'b01: es = w[11:2];
      2'b10: begin eb = es; ea = w[11:2]; end
      default: eref = w[1:0];
    endcase
  endtask

  task automatic t_reset;
    check_all("R1");
  endtask

  task automatic t_write_b;
    send(mk(0, 0, 0, 0, 10'h3FF, 2'b11));
    check_all("R2");
    chk("R10", "ref after B write", 16'(ref_sel), 16'h0);
  endtask

  task automatic t_stage_only;
    send(mk(0, 0, 0, 1, 10'h155, 2'b10));
    check_all("R3");
    chk("R3", "B held", 16'(lat_b), 16'h3FF);
  endtask

  task automatic t_simul;
    send(mk(1, 0, 0, 0, 10'h200, 2'b01));
    check_all("R4");
    chk("R4", "B from stage", 16'(lat_b), 16'h155);
    send(mk(1, 0, 0, 0, 10'h0AA, 2'b00));
    check_all("R4");
    chk("R4", "B unchanged", 16'(lat_b), 16'h155);
  endtask

  task automatic t_ctrl;
    send(mk(1, 0, 0, 1, 10'h3FF, 2'b01)); check_all("R5");
    send(mk(1, 0, 0, 1, 10'h000, 2'b10)); check_all("R5");
    send(mk(1, 0, 0, 1, 10'h000, 2'b11)); check_all("R5");
    send(mk(0, 0, 0, 1, 10'h011, 2'b00));
    chk("R10", "ref held", 16'(ref_sel), 16'h3);
    check_all("R10");
  endtask

  task automatic t_speed;
    send(mk(1, 1, 0, 1, 10'h0, 2'b00)); check_all("R6");
    send(mk(0, 1, 0, 1, 10'h022, 2'b00)); check_all("R6");
    send(mk(0, 0, 0, 1, 10'h033, 2'b00)); check_all("R6");
  endtask

  task automatic t_pdown;
    send(mk(0, 0, 1, 1, 10'h033, 2'b00));
    check_all("R7");
    chk("R7", "out_a gated", 16'(out_code_a), 16'h0);
    send(mk(0, 0, 1, 0, 10'h1C3, 2'b00));
    send(mk(1, 0, 1, 0, 10'h2E7, 2'b00));
    check_all("R8");
    send(mk(0, 0, 0, 1, 10'h044, 2'b00));
    check_all("R7");
    chk("R8", "out_a after wake", 16'(out_code_a), 16'h2E7);
    chk("R8", "out_b after wake", 16'(out_code_b), 16'h1C3);
  endtask

  task automatic t_idle;
    @(negedge clk);
    cmd_word = mk(0, 1, 1, 0, 10'h3FF, 2'b11);
    repeat (4) @(negedge clk);
    check_all("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_b;
    t_stage_only;
    t_simul;
    t_ctrl;
    t_speed;
    t_pdown;
    t_idle;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule